// File: doc/BRIEF.md
# Four-Tap Pixel Interleave Reorderer

This block rebuilds the pixel order that multi-tap cameras put on their link. Pixels of one raster arrive one per clock and are stored in order in one bank of a two-bank line store. When the first pixel of the next raster arrives, the banks trade roles. The raster just completed is then read out as groups of four pixels, one group per clock, while the new raster fills the other bank.

Each of the four output lanes has its own address generator. At the start of a readout it loads a programmed start address. After every group it adds a programmed signed step, and the address wraps at the bank size. With interleaving off the generators use start k and step 4 for lane k, so the raster leaves in its arrival order. A raster longer than the bank keeps its first pixels and drops the rest. If interleaving is on when a pixel is dropped, a sticky overflow flag is raised.

Top module: `il_reorder`

## Requirements
- R1: During and right after reset, out_valid, out_group and ovf_flag are all zero, and both banks hold zero pixels.
- R2: A pixel accepted with in_valid and in_sol high is pixel 0 of a new raster. Each later accepted pixel with in_sol low takes the next index. Pixel i of a raster is stored at bank address i.
- R3: If the closing raster holds L pixels and L > 0, a sol pixel sampled at edge T starts its readout. The readout is ceil(L/4) groups, with out_valid high after edges T+1 through T+ceil(L/4). A raster of zero pixels produces no groups.
- R4: With il_en high at the sol edge, lane k (out_group bits 8k+7:8k) of group g is the stored pixel at address (start_k + g*delta_k) mod 2^ADDR_W. Start_k is tap_start bits [ADDR_W*k +: ADDR_W]. Delta_k is the two's-complement value in the same field of tap_delta.
- R5: With il_en low at the sol edge, lane k of group g is pixel 4g+k of the closed raster, so pixels leave in arrival order.
- R6: Writing the new raster never changes what the ongoing readout returns. Addresses past L return whatever that bank last held: an older raster's pixel, or zero since reset.
- R7: With il_en high, a pixel offered after the bank already holds 2^ADDR_W pixels is dropped and ovf_flag rises after that edge. ovf_flag then stays high until reset.
- R8: With il_en low, pixels past 2^ADDR_W are dropped and ovf_flag keeps its value.
- R9: A sol pixel arriving while a readout is still running cuts off the remaining groups. The readout of the newly closed raster begins on the next clock.
- R10: Cycles with in_valid low write nothing and do not advance the raster, whatever in_sol and in_pix carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| il_en | input | 1 | Interleave enable; sampled at each sol edge for the readout it starts |
| tap_start | input | NTAPS*ADDR_W | Per-lane start address, lane k in field k |
| tap_delta | input | NTAPS*ADDR_W | Per-lane signed address step, lane k in field k |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | Marks the first pixel of a raster |
| in_pix | input | PIX_W | Input pixel |
| out_valid | output | 1 | out_group carries a new group |
| out_group | output | NTAPS*PIX_W | Four reordered pixels, lane k in bits k*PIX_W +: PIX_W |
| ovf_flag | output | 1 | Sticky overflow of an interleaved raster |

## Verification
The bench builds the block with ADDR_W=4, PIX_W=8 and NTAPS=4, so each bank holds 16 pixels. At that size a raster fills its bank, wraps under a negative step, and overflows within a few dozen clocks. The overflow path and the modulo arithmetic, which a 1024-entry bank would rarely reach, are therefore exercised many times. Short rasters put stale bank contents into the last group of a readout. A sol that follows closely after another cuts a readout short.

// File: rtl/il_pkg.sv
package il_pkg;
  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_SHUF = 1'b1
  } il_mode_e;
endpackage

// File: rtl/il_write_ctl.sv
module il_write_ctl #(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              il_en,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic              fill_bank,
  output logic              swap_evt,
  output logic [CNT_W-1:0]  done_len,
  output logic              ovf_flag
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << ADDR_W);

  logic             bank_q;
  logic [CNT_W-1:0] wcnt;
  logic             room;
  logic             drop_evt;

  assign room      = (wcnt < FULL);
  assign swap_evt  = in_valid & in_sol;
  assign drop_evt  = in_valid & ~in_sol & ~room;
  assign wr_en     = swap_evt | (in_valid & room);
  assign wr_bank   = swap_evt ? ~bank_q : bank_q;
  assign wr_addr   = swap_evt ? '0 : wcnt[ADDR_W-1:0];
  assign wr_data   = in_pix;
  assign fill_bank = bank_q;
  assign done_len  = wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      wcnt     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (swap_evt) begin
        bank_q <= ~bank_q;
        wcnt   <= CNT_W'(1);
      end else if (in_valid && room) begin
        wcnt <= wcnt + 1'b1;
      end
      if (drop_evt && il_en) ovf_flag <= 1'b1;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sol && wcnt < FULL) |=> wcnt == $past(wcnt) + 1'b1); // R2
  AST_SOL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> wcnt == CNT_W'(1)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> wcnt == FULL); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R7
  AST_OVF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(il_en)); // R7
endmodule

// File: rtl/il_bank_mem.sv
module il_bank_mem #(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  parameter int NTAPS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_bank,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [PIX_W-1:0]         wr_data,
  input  logic                     rd_bank,
  input  logic [NTAPS*ADDR_W-1:0]  rd_addr,
  output logic [NTAPS*PIX_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PIX_W-1:0] mem [2][DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < DEPTH; i++) mem[b][i] <= '0;
      end
    end else if (wr_en) begin
      mem[wr_bank][wr_addr] <= wr_data;
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_port
    assign rd_data[k*PIX_W +: PIX_W] = mem[rd_bank][rd_addr[k*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/il_tap_gen.sv
module il_tap_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_in,
  input  logic [ADDR_W-1:0] delta_in,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] dlt;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic [ADDR_W-1:0] d);
    return a + d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      dlt  <= '0;
    end else if (load) begin
      addr <= start_in;
      dlt  <= delta_in;
    end else if (step) begin
      addr <= advance(addr, dlt);
    end
  end

  AST_TAP_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr)); // R4
endmodule

// File: rtl/il_read_ctl.sv
module il_read_ctl #(
  parameter int ADDR_W = 10,
  parameter int NTAPS  = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_evt,
  input  logic [CNT_W-1:0] done_len,
  input  logic             fill_bank,
  output logic             rd_bank,
  output logic             rd_step
);
  localparam int TAP_LG = $clog2(NTAPS);
  localparam logic [CNT_W-1:0] GMAX = CNT_W'((1 << ADDR_W) / NTAPS);

  logic [CNT_W-1:0] rd_left;

  function automatic logic [CNT_W-1:0] groups_of(input logic [CNT_W-1:0] len);
    logic [CNT_W-1:0] t;
    t = len + CNT_W'(NTAPS - 1);
    return t >> TAP_LG;
  endfunction

  assign rd_step = (rd_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_left <= '0;
      rd_bank <= 1'b0;
    end else if (swap_evt) begin
      rd_left <= groups_of(done_len);
      rd_bank <= fill_bank;
    end else if (rd_step) begin
      rd_left <= rd_left - 1'b1;
    end
  end

  AST_BANKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |-> rd_bank != fill_bank); // R6
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_left <= GMAX); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && done_len != '0) |=> rd_step); // R9
endmodule

// File: rtl/il_reorder.sv
module il_reorder #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 10,
  parameter int NTAPS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    il_en,
  input  logic [NTAPS*ADDR_W-1:0] tap_start,
  input  logic [NTAPS*ADDR_W-1:0] tap_delta,
  input  logic                    in_valid,
  input  logic                    in_sol,
  input  logic [PIX_W-1:0]        in_pix,
  output logic                    out_valid,
  output logic [NTAPS*PIX_W-1:0]  out_group,
  output logic                    ovf_flag
);
  import il_pkg::*;
  localparam int CNT_W = ADDR_W + 1;

  il_mode_e                mode;
  logic                    wr_en;
  logic                    wr_bank;
  logic [ADDR_W-1:0]       wr_addr;
  logic [PIX_W-1:0]        wr_data;
  logic                    fill_bank;
  logic                    swap_evt;
  logic [CNT_W-1:0]        done_len;
  logic                    rd_bank;
  logic                    rd_step;
  logic [NTAPS*ADDR_W-1:0] rd_addr;
  logic [NTAPS*PIX_W-1:0]  rd_data;

  assign mode = il_en ? MODE_SHUF : MODE_PASS;

  il_write_ctl #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .il_en(il_en),
    .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .fill_bank(fill_bank), .swap_evt(swap_evt), .done_len(done_len),
    .ovf_flag(ovf_flag)
  );

  il_bank_mem #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .NTAPS(NTAPS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  il_read_ctl #(.ADDR_W(ADDR_W), .NTAPS(NTAPS)) u_rd (
    .clk(clk), .rst_n(rst_n), .swap_evt(swap_evt), .done_len(done_len),
    .fill_bank(fill_bank), .rd_bank(rd_bank), .rd_step(rd_step)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic [ADDR_W-1:0] eff_start;
    logic [ADDR_W-1:0] eff_delta;
    assign eff_start = (mode == MODE_SHUF) ? tap_start[k*ADDR_W +: ADDR_W] : ADDR_W'(k);
    assign eff_delta = (mode == MODE_SHUF) ? tap_delta[k*ADDR_W +: ADDR_W] : ADDR_W'(NTAPS);

    il_tap_gen #(.ADDR_W(ADDR_W)) u_tap (
      .clk(clk), .rst_n(rst_n), .load(swap_evt), .step(rd_step),
      .start_in(eff_start), .delta_in(eff_delta),
      .addr(rd_addr[k*ADDR_W +: ADDR_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_group <= '0;
    end else begin
      out_valid <= rd_step;
      if (rd_step) out_group <= rd_data;
    end
  end

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && done_len == '0) |=> ##1 !out_valid); // R3
  AST_GROUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_group))); // R3
endmodule

// File: tb/il_reorder_bench.sv
module il_reorder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int PW = 8;
  localparam int NT = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t_en = 1'b0;
  logic [NT*AW-1:0] t_start = '0;
  logic [NT*AW-1:0] t_delta = '0;
  logic t_valid = 1'b0;
  logic t_sol = 1'b0;
  logic [PW-1:0] t_pix = '0;
  logic out_valid;
  logic [NT*PW-1:0] out_group;
  logic ovf_flag;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";

  logic [PW-1:0] m_mem [2][DEPTH];
  int m_wbank = 0;
  int m_wcnt = 0;
  logic m_ovf = 1'b0;
  logic [NT*PW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  il_reorder #(.PIX_W(PW), .ADDR_W(AW), .NTAPS(NT)) u_il_reorder (
    .clk(clk), .rst_n(rst_n), .il_en(t_en), .tap_start(t_start), .tap_delta(t_delta),
    .in_valid(t_valid), .in_sol(t_sol), .in_pix(t_pix),
    .out_valid(out_valid), .out_group(out_group), .ovf_flag(ovf_flag)
  );

  task automatic check_bit(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b", cur_tag, what, act, exp);
    end
  endtask

  task automatic check_grp(input logic [NT*PW-1:0] act, input logic [NT*PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s out_group act=%h exp=%h", cur_tag, act, exp);
    end
  endtask

  // Reference step for the inputs sampled at the edge just passed.
  task automatic model_check();
    logic ev;
    logic [NT*PW-1:0] eg;
    ev = 1'b0;
    eg = '0;
    if (exp_q.size() > 0) begin
      ev = 1'b1;
      eg = exp_q.pop_front();
    end
    if (t_valid) begin
      if (t_sol) begin
        int ng;
        ng = (m_wcnt + NT - 1) / NT;
        exp_q.delete();
        for (int g = 0; g < ng; g++) begin
          logic [NT*PW-1:0] grp;
          for (int k = 0; k < NT; k++) begin
            int a;
            if (t_en) a = (int'(t_start[k*AW +: AW]) + g * int'(t_delta[k*AW +: AW])) & (DEPTH - 1);
            else      a = g * NT + k;
            grp[k*PW +: PW] = m_mem[m_wbank][a];
          end
          exp_q.push_back(grp);
        end
        m_wbank = 1 - m_wbank;
        m_mem[m_wbank][0] = t_pix;
        m_wcnt = 1;
      end else if (m_wcnt < DEPTH) begin
        m_mem[m_wbank][m_wcnt] = t_pix;
        m_wcnt++;
      end else if (t_en) begin
        m_ovf = 1'b1;
      end
    end
    check_bit("R3 out_valid", out_valid, ev);
    if (ev) check_grp(out_group, eg);
    check_bit("ovf_flag R7 R8", ovf_flag, m_ovf);
  endtask

  task automatic cyc(input logic v, input logic s, input logic [PW-1:0] p);
    @(negedge clk);
    model_check();
    t_valid = v;
    t_sol = s;
    t_pix = p;
  endtask

  task automatic raster(input int n, input int base);
    for (int i = 0; i < n; i++) cyc(1'b1, i == 0, PW'((base + i * 37) & 255));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, i[0], PW'(8'hA5 ^ i));
  endtask

  task automatic set_cfg(input logic en, input int s0, input int s1, input int s2, input int s3,
                         input int d0, input int d1, input int d2, input int d3);
    t_en = en;
    t_start = {AW'(s3), AW'(s2), AW'(s1), AW'(s0)};
    t_delta = {AW'(d3), AW'(d2), AW'(d1), AW'(d0)};
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) m_mem[b][i] = '0;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check_bit("reset out_valid", out_valid, 1'b0);
    check_grp(out_group, '0);
    check_bit("reset ovf_flag", ovf_flag, 1'b0);
    rst_n = 1'b1;

    cur_tag = "R2 R5 R6";
    set_cfg(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    raster(8, 16);
    raster(6, 50);
    cur_tag = "R10 R5";
    idle(5);
    raster(16, 90);
    raster(3, 7);
    idle(6);

    cur_tag = "R4 R6";
    set_cfg(1'b1, 0, 8, 4, 12, 1, 1, 1, 1);
    raster(16, 3);
    raster(16, 120);
    set_cfg(1'b1, 15, 7, 3, 0, 15, 2, 5, 0);
    raster(16, 200);
    raster(10, 11);
    set_cfg(1'b1, 2, 9, 14, 5, 3, 13, 7, 8);
    raster(16, 60);
    idle(4);

    cur_tag = "R9";
    raster(16, 33);
    raster(1, 77);
    raster(2, 99);
    raster(16, 140);
    idle(2);

    cur_tag = "R8";
    set_cfg(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    raster(20, 45);
    raster(16, 170);
    idle(3);

    cur_tag = "R7";
    set_cfg(1'b1, 1, 0, 3, 2, 4, 4, 4, 4);
    raster(20, 81);
    raster(16, 66);
    set_cfg(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    raster(4, 5);
    raster(1, 9);
    idle(8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    failures++;
    $display("FAIL watchdog expired in %s", cur_tag);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule